// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit logical address into a 30-bit physical address. It looks up one entry of a flat, single-level page table held in memory. A caller presents one request at a time: a logical address, an access kind, the table's base address and its length in entries. For an in-range page the walker issues a single 32-bit word read on a plain valid/ready memory request channel. It then takes the entry from a one-beat response channel and returns either a physical address or a fault with its cause.

The logical address is a 20-bit page number above a 12-bit byte offset. Pages and frames are 4096 bytes. The physical address joins the entry's 18-bit frame number with the unchanged offset, so the offset needs no bound check. The demand-paging bits of a fetched entry go back to the caller as they are, and the walker takes no action on them. Base and length are sampled when a request is accepted, so the caller may reprogram them for the next process while a walk is in flight.

Top module: `page_walk_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: When the page number (`req_vaddr[31:12]`) is not below `tbl_limit`, the walker answers with cause 1 (bound) and issues no memory read. A limit of 0 makes every request fault this way.
- R3: For an in-range page, exactly one read is issued, at address `tbl_base + 4 * page_number` (modulo 2^32).
- R4: A fetched entry with bit 0 (valid) clear yields cause 2 (invalid), whatever its other bits hold.
- R5: The entry holds read permission in bit 4, write in bit 5 and execute in bit 6. Access kind 0 is read, 1 is write, 2 is execute and 3 is reserved. If the bit for the kind is clear, or the kind is 3, the answer is cause 3 (permission). A valid entry only reaches cause 3 after passing the valid check.
- R6: On success, `rsp_paddr` is entry bits 24:7 (frame) followed by `req_vaddr[11:0]`. Entry bits 31:25 have no effect. `rsp_fault` is 0 and the cause is 0. On any fault, `rsp_fault` is 1 and `rsp_paddr` is 0.
- R7: `rsp_dp` carries entry bits 3:1 for every response that fetched an entry, including invalid and permission faults. It is 0 on a bound fault.
- R8: `req_ready` is 0 from the cycle after acceptance until the response. `rsp_valid` is high for exactly one cycle. `req_ready` returns to 1 the cycle after that.
- R9: Once raised, `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.
- R10: `tbl_base` and `tbl_limit` are sampled at acceptance. Changing them during a walk has no effect on the read address of that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| tbl_base | input | 32 | Byte address of table entry 0 |
| tbl_limit | input | 21 | Number of entries in the table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 bound, 2 invalid, 3 permission |
| rsp_paddr | output | 30 | Physical address, 0 on fault |
| rsp_dp | output | 3 | Demand-paging bits of the fetched entry |

## Verification
The assertions assume that memory never answers unless a read has been accepted and is still open. They also assume that exactly one response beat arrives for each accepted read. The bench keeps to this because its memory model drives `mem_rsp_valid` for one cycle, only after it has completed a handshake on the request channel, and never otherwise. Requests are raised only while `req_ready` is high. The stimulus varies stall length and response latency, and it changes the base register in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W    = 32;
    localparam int PA_W    = 30;
    localparam int OFS_W   = 12;
    localparam int VPN_W   = VA_W - OFS_W;
    localparam int FRAME_W = PA_W - OFS_W;
    localparam int DP_W    = 3;
    localparam int PERM_W  = 3;
    localparam int WORD_W  = 32;
    localparam int LIM_W   = VPN_W + 1;
    localparam int SPARE_W = WORD_W - FRAME_W - PERM_W - DP_W - 1;
    localparam int ESZ_LG  = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUND   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PERM    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic [FRAME_W-1:0] frame;
        logic [PERM_W-1:0]  perm;
        logic [DP_W-1:0]    dp;
        logic               valid;
    } pte_t;

    typedef struct packed {
        fault_e             cause;
        logic [PA_W-1:0]    paddr;
        logic [DP_W-1:0]    dp;
    } walk_result_t;

    function automatic logic kind_allowed(input logic [PERM_W-1:0] perm,
                                          input access_e kind);
        case (kind)
            ACC_READ:  return perm[0];
            ACC_WRITE: return perm[1];
            ACC_EXEC:  return perm[2];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ptw_index_calc.sv
module ptw_index_calc
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]   vaddr,
    input  logic [WORD_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    output logic              in_range,
    output logic [WORD_W-1:0] entry_addr
);
    logic [VPN_W-1:0]  vpn;
    logic [WORD_W-1:0] scaled;

    always_comb begin
        vpn        = vaddr[VA_W-1:OFS_W];
        in_range   = {1'b0, vpn} < limit;
        scaled     = '0;
        scaled[VPN_W+ESZ_LG-1:0] = {vpn, {ESZ_LG{1'b0}}};
        entry_addr = base + scaled;
    end
endmodule

// File: rtl/ptw_entry_judge.sv
module ptw_entry_judge
    import ptw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  access_e           kind,
    input  logic [OFS_W-1:0]  offset,
    output walk_result_t      result
);
    pte_t entry;

    always_comb begin
        entry        = pte_t'(word);
        result.dp    = entry.dp;
        result.paddr = '0;
        if (!entry.valid) begin
            result.cause = FLT_INVALID;
        end else if (!kind_allowed(entry.perm, kind)) begin
            result.cause = FLT_PERM;
        end else begin
            result.cause = FLT_NONE;
            result.paddr = {entry.frame, offset};
        end
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  access_e           req_kind,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic              in_range,
    input  logic [WORD_W-1:0] entry_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    output access_e           held_kind,
    output logic [OFS_W-1:0]  held_offset,
    input  walk_result_t      judged,
    output logic              rsp_valid,
    output walk_result_t      result
);
    walk_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            mem_req_addr <= '0;
            held_kind    <= ACC_READ;
            held_offset  <= '0;
            result       <= '{cause: FLT_NONE, paddr: '0, dp: '0};
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    mem_req_addr <= entry_addr;
                    held_kind    <= req_kind;
                    held_offset  <= req_offset;
                    if (in_range) begin
                        state <= ST_ISSUE;
                    end else begin
                        result <= '{cause: FLT_BOUND, paddr: '0, dp: '0};
                        state  <= ST_RESP;
                    end
                end
                ST_ISSUE: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    result <= judged;
                    state  <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_ISSUE);
    assign rsp_valid     = (state == ST_RESP);

    // R9: an open read request is held steady until memory takes it
    assert_hold_read_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R8: the result strobe lasts one cycle and is followed by idle
    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && req_ready);

    // R8: no new request can enter while a read is outstanding
    assert_busy_during_read_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    // R1: first cycle after reset is idle and quiet
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> req_ready && !mem_req_valid && !rsp_valid);
endmodule

// File: rtl/page_walk_unit.sv
module page_walk_unit
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [WORD_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [DP_W-1:0]   rsp_dp
);
    logic              in_range;
    logic [WORD_W-1:0] entry_addr;
    access_e           held_kind;
    logic [OFS_W-1:0]  held_offset;
    walk_result_t      judged;
    walk_result_t      result;

    ptw_index_calc u_index (
        .vaddr      (req_vaddr),
        .base       (tbl_base),
        .limit      (tbl_limit),
        .in_range   (in_range),
        .entry_addr (entry_addr)
    );

    ptw_entry_judge u_judge (
        .word   (mem_rsp_data),
        .kind   (held_kind),
        .offset (held_offset),
        .result (judged)
    );

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_kind      (access_e'(req_kind)),
        .req_offset    (req_vaddr[OFS_W-1:0]),
        .in_range      (in_range),
        .entry_addr    (entry_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .held_kind     (held_kind),
        .held_offset   (held_offset),
        .judged        (judged),
        .rsp_valid     (rsp_valid),
        .result        (result)
    );

    assign rsp_cause = result.cause;
    assign rsp_fault = (result.cause != FLT_NONE);
    assign rsp_paddr = result.paddr;
    assign rsp_dp    = result.dp;

    // R2: a bound fault answers straight from idle, with no read in between
    assert_bound_no_read_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_cause == FLT_BOUND |-> $past(req_ready) && !$past(mem_req_valid));
endmodule

// File: tb/page_walk_unit_test.sv
module page_walk_unit_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        req_valid = 0;
    logic        req_ready;
    logic [31:0] req_vaddr = 0;
    logic [1:0]  req_kind = 0;
    logic [31:0] tbl_base = 0;
    logic [20:0] tbl_limit = 0;
    logic        mem_req_valid;
    logic        mem_req_ready = 0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = 32'hDEAD_BEEF;
    logic        rsp_valid, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [29:0] rsp_paddr;
    logic [2:0]  rsp_dp;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem [int unsigned];

    always #4 clk = ~clk;

    page_walk_unit uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pte(input logic [17:0] frame, input logic [2:0] perm,
                                        input logic [2:0] dp, input logic v, input logic [6:0] spare);
        return {spare, frame, perm, dp, v};
    endfunction

    function automatic logic [31:0] fetch(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic txn(input logic [31:0] va, input logic [1:0] kind, input logic [31:0] base,
                       input logic [20:0] limit, input int stall, input int lat,
                       input logic [31:0] base_after, input string tag);
        logic [19:0] vpn;
        logic [31:0] ea, e;
        int reads;
        bit got, busy_ok, hold_ok, need_read, perm_ok;
        logic [1:0]  exp_cause;
        logic [29:0] exp_pa;
        logic [2:0]  exp_dp;
        vpn = va[31:12];
        ea = base + {10'd0, vpn, 2'b00};
        need_read = ({1'b0, vpn} < limit);
        e = fetch(ea);
        perm_ok = (kind == 2'd0) ? e[4] : (kind == 2'd1) ? e[5] : (kind == 2'd2) ? e[6] : 1'b0;
        exp_pa = 0;
        exp_dp = need_read ? e[3:1] : 3'd0;
        if (!need_read)      exp_cause = 2'd1;
        else if (!e[0])      exp_cause = 2'd2;
        else if (!perm_ok)   exp_cause = 2'd3;
        else begin exp_cause = 2'd0; exp_pa = {e[24:7], va[11:0]}; end

        @(negedge clk);
        chk(req_ready === 1'b1, {tag, " R8 ready when idle"}, req_ready, 1);
        tbl_base = base; tbl_limit = limit; req_vaddr = va; req_kind = kind; req_valid = 1;
        @(negedge clk);
        req_valid = 0; tbl_base = base_after; tbl_limit = 21'd0;
        reads = 0; got = 0; busy_ok = 1; hold_ok = 1;
        for (int n = 0; n < 100 && !got; n++) begin
            if (rsp_valid) begin got = 1; break; end
            if (req_ready) busy_ok = 0;
            if (mem_req_valid) begin
                chk(mem_req_addr === ea, {tag, " R3/R10 entry address"}, mem_req_addr, ea);
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    if (!mem_req_valid || mem_req_addr !== ea) hold_ok = 0;
                end
                mem_req_ready = 1;
                @(negedge clk);
                mem_req_ready = 0;
                reads++;
                for (int l = 0; l < lat; l++) @(negedge clk);
                mem_rsp_valid = 1; mem_rsp_data = e;
                @(negedge clk);
                mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_BEEF;
            end else begin
                @(negedge clk);
            end
        end
        chk(got, {tag, " response seen"}, got, 1);
        chk(busy_ok, {tag, " R8 busy during walk"}, busy_ok, 1);
        chk(hold_ok, {tag, " R9 request held"}, hold_ok, 1);
        chk(reads == (need_read ? 1 : 0), {tag, " R2/R3 read count"}, reads, need_read);
        chk(rsp_cause === exp_cause, {tag, " R2/R4/R5 cause"}, rsp_cause, exp_cause);
        chk(rsp_fault === (exp_cause != 0), {tag, " R6 fault flag"}, rsp_fault, exp_cause != 0);
        chk(rsp_paddr === exp_pa, {tag, " R6 paddr"}, rsp_paddr, exp_pa);
        chk(rsp_dp === exp_dp, {tag, " R7 dp bits"}, rsp_dp, exp_dp);
        @(negedge clk);
        chk(!rsp_valid && req_ready, {tag, " R8 single strobe"}, {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] b;
        b = 32'h0001_0000;
        mem[b + 4*5]  = pte(18'h2ABCD, 3'b001, 3'b101, 1, 7'h55);
        mem[b + 4*6]  = pte(18'h00F0F, 3'b100, 3'b010, 1, 7'h7F);
        mem[b + 4*7]  = pte(18'h3FFFF, 3'b111, 3'b111, 0, 7'h00);
        mem[b + 4*9]  = pte(18'h12345, 3'b111, 3'b011, 1, 7'h01);
        mem[b + 4*15] = pte(18'h00001, 3'b010, 3'b000, 1, 7'h00);
        mem[b + 32'h003F_FFFC] = pte(18'h3C3C3, 3'b011, 3'b110, 1, 7'h2A);

        repeat (3) @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R1 during reset",
            {req_ready, mem_req_valid, rsp_valid}, 3'b100);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R1 after reset",
            {req_ready, mem_req_valid, rsp_valid}, 3'b100);

        txn({20'd5, 12'h3C4}, 2'd0, b, 21'd16, 0, 0, b, "read ok R6 R7");
        txn({20'd5, 12'h001}, 2'd1, b, 21'd16, 0, 1, b, "write denied R5");
        txn({20'd6, 12'hFFF}, 2'd2, b, 21'd16, 2, 0, b, "exec ok R5");
        txn({20'd6, 12'h000}, 2'd0, b, 21'd16, 0, 0, b, "read denied R5");
        txn({20'd7, 12'h123}, 2'd0, b, 21'd16, 0, 2, b, "invalid R4");
        txn({20'd9, 12'h456}, 2'd3, b, 21'd16, 0, 0, b, "reserved kind R5");
        txn({20'd15, 12'hABC}, 2'd1, b, 21'd16, 3, 4, b, "last entry R2");
        txn({20'd16, 12'hABC}, 2'd0, b, 21'd16, 0, 0, b, "at limit R2");
        txn({20'd0, 12'h000}, 2'd0, b, 21'd0, 0, 0, b, "zero limit R2");
        txn({20'd8, 12'h010}, 2'd0, b, 21'd16, 1, 1, b, "unwritten entry R4");
        txn({20'd5, 12'h7A5}, 2'd0, b, 21'd16, 1, 3, 32'h0F00_0000, "base change R10");
        txn({20'hFFFFF, 12'h5A5}, 2'd1, b, 21'h100000, 0, 0, b, "max page R3");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule